// File: doc/BRIEF.md
# Address-Encoded Register Access Unit

This block is a host-facing file of 32 byte-wide control registers. It decodes a 9-bit byte-bus address in three fields. The low five bits name a register. The next two bits name the action to take on it: store the data byte, AND the data byte into the register, OR the data byte into the register, or return the register. The top two bits name the area being addressed. Because the action is carried in the address, host software can set or clear individual bits with one bus cycle instead of a read, a modify and a write.

Only the control area holds writable storage. Of its 32 slots, 18 are real registers: indices 0x00 to 0x0F and the paging pair at 0x18/0x19. The even relocation register drives the shared-memory base address. The odd relocation register reports a fixed memory-size code. The even paging register switches paging on. The remaining areas are read-only. One is reserved and returns zero. The other two return identification bytes computed from the index. Any attempt to modify something that cannot be modified raises a one-cycle violation pulse and sets the access-interrupt flag in the even host interrupt status register.

Top module: `aop_unit`

## Requirements
- R1: A strobe with address[8:7]=00 and address[6:5]=11 returns, on bus_rdata from the clock edge that samples the strobe, the byte held in the control register named by address[4:0]. bus_rdata holds its value between reads.
- R2: A strobe with address[8:7]=00 and address[6:5]=00 on a valid index stores bus_wdata into that register at the sampling edge.
- R3: Operation 01 on a valid control index replaces the register with its old value ANDed with bus_wdata.
- R4: Operation 10 on a valid control index replaces the register with its old value ORed with bus_wdata.
- R5: A read (operation 11) changes no register, so two reads in a row return the same byte.
- R6: A read of the reserved area (address[8:7]=01), or of a control index outside 0x00–0x0F and 0x18–0x19, returns 0x00.
- R7: Area 10 returns (ID_SEED + index) mod 256. Area 11 returns 0x55 for an even index and 0xAA for an odd index. Neither area can be written.
- R8: A write, AND or OR aimed at an invalid control index or at any area other than 00 pulses acc_err high for exactly the cycle after the strobe. It sets bit 2 of register 0x08, which is visible on acc_irq, and changes no other stored bit.
- R9: sram_base_addr equals bits [7:1] of register 0x00 placed at address bits [19:13], with bits [12:0] zero.
- R10: Bits [3:2] of register 0x01 always read as the SIZE_CODE parameter (00=8 KB, 01=16 KB, 10=32 KB, 11=64 KB), are driven on sram_size_code, and cannot be changed. The other bits of 0x01 are writable.
- R11: paging_on is high exactly when bits [7:6] of register 0x18 are both 1, for example after a write of 0xC0.
- R12: After reset every register is 0x00 except 0x01, which holds SIZE_CODE in bits [3:2]. bus_rdata, acc_err, acc_irq and paging_on are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Area[8:7], operation[6:5], register index[4:0] |
| bus_wdata | input | 8 | Data byte for write, AND or OR |
| bus_strb | input | 1 | Access strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| acc_err | output | 1 | One-cycle illegal-access pulse |
| acc_irq | output | 1 | Access-interrupt flag, bit 2 of register 0x08 |
| sram_base_addr | output | 20 | Shared-memory base address |
| sram_size_code | output | 2 | Memory-size code from register 0x01 |
| paging_on | output | 1 | Paging enable |

## Verification
The bench goes after four kinds of error. AND and OR must combine with the old register value: a design that wrote the raw byte would show the wrong value on the next read and on sram_base_addr. A modify aimed at an invalid index or a read-only area must leave storage untouched: a design that decoded only the index, and not the area, would overwrite a real register and move the base or paging outputs. The size bits of 0x01 must survive a write of 0xFF, and the access flag must be set by a violation and cleared by an AND. A long run of mixed accesses is also compared on every cycle against a behavioural model, which catches swapped operation codes and stale read data.

// File: rtl/aop_pkg.sv
package aop_pkg;
  localparam int IDX_W    = 5;
  localparam int OP_W     = 2;
  localparam int AREA_W   = 2;
  localparam int ADDR_W   = IDX_W + OP_W + AREA_W;
  localparam int DATA_W   = 8;
  localparam int NREG     = 1 << IDX_W;
  localparam int BASE_LSB = 13;
  localparam int BASE_W   = 20;

  localparam int RELOC_EV_IDX = 0;
  localparam int RELOC_OD_IDX = 1;
  localparam int HIRQ_EV_IDX  = 8;
  localparam int PAGE_EV_IDX  = 24;
  localparam int ACC_BIT      = 2;

  typedef enum logic [OP_W-1:0] {
    OP_WR  = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_RD  = 2'b11
  } op_e;

  typedef enum logic [AREA_W-1:0] {
    AR_CTL = 2'b00,
    AR_RSV = 2'b01,
    AR_IDA = 2'b10,
    AR_IDB = 2'b11
  } area_e;

  function automatic logic idx_is_real(input logic [IDX_W-1:0] i);
    return (i < IDX_W'(16)) || (i == IDX_W'(PAGE_EV_IDX)) || (i == IDX_W'(PAGE_EV_IDX + 1));
  endfunction
endpackage

// File: rtl/aop_decode.sv
module aop_decode
  import aop_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              strb,
  output logic [IDX_W-1:0]  idx,
  output op_e               op,
  output area_e             area,
  output logic              do_mod,
  output logic              do_rd,
  output logic              viol
);
  logic mod_req;
  logic tgt_ok;

  always_comb begin
    idx     = addr[IDX_W-1:0];
    op      = op_e'(addr[IDX_W +: OP_W]);
    area    = area_e'(addr[IDX_W+OP_W +: AREA_W]);
    mod_req = strb && (op != OP_RD);
    tgt_ok  = (area == AR_CTL) && idx_is_real(idx);
    do_mod  = mod_req && tgt_ok;
    viol    = mod_req && !tgt_ok;
    do_rd   = strb && (op == OP_RD);
  end
endmodule

// File: rtl/aop_idrom.sv
module aop_idrom
  import aop_pkg::*;
#(
  parameter logic [7:0] ID_SEED = 8'h3C
) (
  input  logic             sel_b,
  input  logic [IDX_W-1:0] idx,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] PAT_EVEN = 8'h55;
  localparam logic [DATA_W-1:0] PAT_ODD  = 8'hAA;

  always_comb begin
    if (sel_b) dout = idx[0] ? PAT_ODD : PAT_EVEN;
    else       dout = ID_SEED + DATA_W'(idx);
  end
endmodule

// File: rtl/aop_regbank.sv
module aop_regbank
  import aop_pkg::*;
#(
  parameter logic [1:0] SIZE_CODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  op_e               op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_acc,
  output logic [DATA_W-1:0] regs_o [NREG]
);
  localparam logic [DATA_W-1:0] ODD_RST = DATA_W'({SIZE_CODE, 2'b00});

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IS_IRQ  = (g == HIRQ_EV_IDX);
    localparam bit IS_SIZE = (g == RELOC_OD_IDX);
    localparam logic [DATA_W-1:0] RST_V = IS_SIZE ? ODD_RST : '0;

    logic [DATA_W-1:0] q, d;
    logic hit, en;

    always_comb begin
      hit = mod_en && (idx == IDX_W'(g));
      en  = hit || (IS_IRQ && set_acc);
      d   = q;
      if (hit) begin
        case (op)
          OP_WR:   d = wdata;
          OP_AND:  d = q & wdata;
          OP_OR:   d = q | wdata;
          default: d = q;
        endcase
      end
      if (IS_IRQ && set_acc) d[ACC_BIT] = 1'b1;
      if (IS_SIZE)           d[3:2]     = SIZE_CODE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (en) q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/aop_unit.sv
module aop_unit
  import aop_pkg::*;
#(
  parameter logic [1:0] SIZE_CODE = 2'b10,
  parameter logic [7:0] ID_SEED   = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_strb,
  output logic [7:0]        bus_rdata,
  output logic              acc_err,
  output logic              acc_irq,
  output logic [19:0]       sram_base_addr,
  output logic [1:0]        sram_size_code,
  output logic              paging_on
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [IDX_W-1:0]  idx;
  op_e               op;
  area_e             area;
  logic              do_mod, do_rd, viol;
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rom_q, rd_val;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q;

  aop_decode u_dec (
    .addr(bus_addr), .strb(bus_strb), .idx(idx), .op(op), .area(area),
    .do_mod(do_mod), .do_rd(do_rd), .viol(viol)
  );

  aop_regbank #(.SIZE_CODE(SIZE_CODE)) u_bank (
    .clk(clk), .rst_n(rst_i), .mod_en(do_mod), .op(op), .idx(idx),
    .wdata(bus_wdata), .set_acc(viol), .regs_o(regs)
  );

  aop_idrom #(.ID_SEED(ID_SEED)) u_rom (
    .sel_b(area == AR_IDB), .idx(idx), .dout(rom_q)
  );

  always_comb begin
    case (area)
      AR_CTL:  rd_val = idx_is_real(idx) ? regs[idx] : '0;
      AR_RSV:  rd_val = '0;
      default: rd_val = rom_q;
    endcase
    rdata_d = rdata_q;
    if (do_rd) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (do_rd) rdata_q <= rdata_d;
      err_q <= viol;
    end
  end

  assign bus_rdata      = rdata_q;
  assign acc_err        = err_q;
  assign acc_irq        = regs[HIRQ_EV_IDX][ACC_BIT];
  assign sram_base_addr = {regs[RELOC_EV_IDX][7:1], BASE_LSB'(0)};
  assign sram_size_code = regs[RELOC_OD_IDX][3:2];
  assign paging_on      = &regs[PAGE_EV_IDX][7:6];

  assert_err_flags_irq_R8: assert property (@(posedge clk) disable iff (!rst_i)
    acc_err |-> acc_irq);
  assert_viol_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_i)
    viol |=> ($stable(sram_base_addr) && $stable(paging_on)));
  assert_rsv_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (do_rd && area == AR_RSV) |=> (bus_rdata == 8'h00));
  assert_size_bits_fixed_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (do_rd && area == AR_CTL && idx == IDX_W'(RELOC_OD_IDX)) |=> (bus_rdata[3:2] == SIZE_CODE));
  assert_rdata_holds_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !do_rd |=> $stable(bus_rdata));
  assert_paging_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(paging_on) |-> $past(do_mod && idx == IDX_W'(PAGE_EV_IDX)));
endmodule

// File: tb/aop_unit_tb.sv
module aop_unit_tb;
  localparam logic [1:0] SZ   = 2'b10;
  localparam logic [7:0] SEED = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_strb = 1'b0;
  logic [7:0]  bus_rdata;
  logic        acc_err, acc_irq, paging_on;
  logic [19:0] sram_base_addr;
  logic [1:0]  sram_size_code;

  aop_unit #(.SIZE_CODE(SZ), .ID_SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_rdata(bus_rdata), .acc_err(acc_err), .acc_irq(acc_irq),
    .sram_base_addr(sram_base_addr), .sram_size_code(sram_size_code), .paging_on(paging_on)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m [32];
  logic [7:0] exp_rd;
  logic       exp_err;

  function automatic bit real_idx(int i);
    return (i <= 15) || (i == 24) || (i == 25);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "rdata", 32'(bus_rdata), 32'(exp_rd));
    chk(tag, "acc_err", 32'(acc_err), 32'(exp_err));
    chk(tag, "acc_irq", 32'(acc_irq), 32'(m[8][2]));
    chk("R9", "base", 32'(sram_base_addr), 32'({m[0][7:1], 13'h0}));
    chk("R10", "size", 32'(sram_size_code), 32'(SZ));
    chk("R11", "paging", 32'(paging_on), 32'(m[24][7] & m[24][6]));
  endtask

  // one access: drive at a falling edge, check at the next falling edge
  task automatic acc(string tag, int area, int op, int idx, logic [7:0] d);
    bit ok;
    bus_addr  = {2'(area), 2'(op), 5'(idx)};
    bus_wdata = d;
    bus_strb  = 1'b1;
    ok = (area == 0) && real_idx(idx);
    exp_err = 1'b0;
    if (op == 3) begin
      if (area == 0)      exp_rd = ok ? m[idx] : 8'h00;
      else if (area == 1) exp_rd = 8'h00;
      else if (area == 2) exp_rd = SEED + 8'(idx);
      else                exp_rd = (idx % 2 == 1) ? 8'hAA : 8'h55;
    end else if (!ok) begin
      exp_err = 1'b1;
      m[8][2] = 1'b1;
    end else begin
      if (op == 0)      m[idx] = d;
      else if (op == 1) m[idx] = m[idx] & d;
      else              m[idx] = m[idx] | d;
      if (idx == 1) m[1][3:2] = SZ;
    end
    @(negedge clk);
    bus_strb = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] first;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    m[1] = {4'h0, SZ, 2'b00};
    exp_rd = 8'h00;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R12");
    acc("R12", 0, 3, 8, 8'h00);
    acc("R12", 0, 3, 1, 8'h00);

    // R2 R9 R1: write then read the relocation register
    acc("R2", 0, 0, 0, 8'hA5);
    acc("R1", 0, 3, 0, 8'h00);
    // R3: AND
    acc("R3", 0, 1, 0, 8'h0F);
    acc("R3", 0, 3, 0, 8'h00);
    // R4: OR
    acc("R4", 0, 0, 14, 8'h0C);
    acc("R4", 0, 2, 14, 8'hF0);
    acc("R4", 0, 3, 14, 8'h00);
    // R5: reads leave state alone
    acc("R5", 0, 3, 14, 8'hFF);
    first = bus_rdata;
    acc("R5", 0, 3, 14, 8'h00);
    chk("R5", "repeat read", 32'(bus_rdata), 32'(first));
    // R10: size bits are read-only
    acc("R10", 0, 0, 1, 8'hFF);
    acc("R10", 0, 3, 1, 8'h00);
    acc("R10", 0, 1, 1, 8'h00);
    acc("R10", 0, 3, 1, 8'h00);
    // R11: paging enable
    acc("R11", 0, 0, 24, 8'hC0);
    acc("R11", 0, 1, 24, 8'h80);
    acc("R11", 0, 2, 24, 8'h40);
    acc("R11", 0, 3, 24, 8'h00);
    // R8: violations
    acc("R8", 0, 0, 16, 8'hFF);
    acc("R8", 0, 3, 0, 8'h00);
    acc("R8", 0, 1, 8, 8'hFB);
    acc("R8", 1, 0, 0, 8'h00);
    acc("R8", 2, 2, 24, 8'h00);
    acc("R8", 3, 1, 0, 8'h00);
    acc("R8", 0, 3, 0, 8'h00);
    acc("R8", 0, 2, 31, 8'h01);
    acc("R8", 0, 0, 8, 8'h00);
    // R6: zero reads
    acc("R6", 0, 3, 16, 8'h00);
    acc("R6", 1, 3, 5, 8'h00);
    acc("R6", 0, 3, 26, 8'h00);
    // R7: identification areas
    acc("R7", 2, 3, 3, 8'h00);
    acc("R7", 2, 3, 31, 8'h00);
    acc("R7", 3, 3, 4, 8'h00);
    acc("R7", 3, 3, 5, 8'h00);

    // mixed traffic against the model (R1)
    for (int k = 0; k < 600; k++) begin
      int a, o, ix;
      a  = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      o  = int'($urandom % 4);
      ix = (($urandom % 3) == 0) ? int'($urandom % 32) : int'($urandom % 16);
      acc("R1", a, o, ix, 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule